// File: doc/BRIEF.md
# Time-Multiplexed FM Operator Datapath

This block computes the outputs of 24 FM operators and six channels, one operator at a time. A 144-cycle frame is split into 24 slots of six cycles. Slot `n` serves operator `n`, and each group of four consecutive operators forms one channel. In every slot the block does four things:

- It advances that operator's 32-bit phase accumulator by a phase increment.
- It turns ten bits of the accumulator into a sine sample. This is a lookup in a logarithmic half-wave table, then an addition of the operator's attenuation in the log domain, then a conversion back to linear through an exponent table and a shift.
- It applies the sign.
- It publishes the signed result with a one-cycle strobe.

On the fourth operator of each channel, the block also combines the stored results of that channel's operators into a channel sample, following a 3-bit algorithm number. The choice of operators depends on that number.

The surrounding chip presents the per-slot inputs combinationally against the exported slot index: the increment, the attenuation and the algorithm of the current channel. These inputs must stay stable for the whole slot. A control input removes the last channel from service: while it is high, that channel's operators neither advance nor produce output. Both lookup tables are built at elaboration from closed-form expressions.

Top module: `fmop_core`

## Requirements
- R1: `slotIdx` holds each value for exactly 6 clock cycles and steps 0,1,…,23, then wraps to 0. A full frame is 144 cycles.
- R2: In each active slot `k`, accumulator `k` (32 bits, modulo 2^32) is increased by `phaseInc`. The operator phase is bits [19:10] of the new accumulator value.
- R3: The log-attenuation of the sine is L(i) = floor(-log2(sin((2i+1)·π/2048))·256 + 0.5), where i is phase bits [8:0].
- R4: The exponent index is L(i) + `envAtten` (13 bits). It saturates at 8191 instead of wrapping.
- R5: For index x, with f = x mod 256 and s = floor(x/256) − 2, the magnitude is floor(2^(−(f+1)/256)·2048 + 0.5). That value is shifted right by s, or left by −s when s is negative. The magnitude is therefore at most 8168.
- R6: When phase bit 9 is 1, `opOut` is the two's-complement negation of the magnitude. Otherwise it is the magnitude.
- R7: Each active slot produces exactly one one-cycle `opValid` pulse while `slotIdx` still equals that slot. `opIdx` carries the slot number during the pulse.
- R8: After the fourth operator (local index 3) of channel c, `chanValid` pulses for one cycle with `chanIdx` = c. `chanOut` is formed from the channel's local operators o0..o3, using `chanAlg` of that slot:
  - algorithms 0–3: o3
  - algorithm 4: o3+o1
  - algorithms 5 and 6: o1+o2+o3
  - algorithm 7: o0+o1+o2+o3
- R9: If `dacEnable` is high at the start of slots 20–23, those slots:
  - do not advance their accumulators;
  - produce no `opValid`;
  - produce no `chanValid` for channel 5.
- R10: While `rstN` is low, all accumulators and outputs are zero, `slotIdx` is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| dacEnable | input | 1 | Removes the last channel's operators from service |
| phaseInc | input | 32 | Phase increment for the operator of the current slot |
| envAtten | input | 13 | Log-domain attenuation for the current slot (8 fractional bits) |
| chanAlg | input | 3 | Algorithm number of the current slot's channel |
| slotIdx | output | 5 | Current operator slot |
| opValid | output | 1 | One-cycle strobe: new operator result |
| opIdx | output | 5 | Operator number of the result |
| opOut | output | 16 | Signed operator result |
| chanValid | output | 1 | One-cycle strobe: new channel result |
| chanIdx | output | 3 | Channel number of the result |
| chanOut | output | 16 | Signed channel result |

## Verification
A corrupted accumulator is not masked. It changes that operator's `opOut` in the same frame it goes wrong, and again every later frame, because the phase error persists. A missing saturation, a wrong shift direction or a lost sign appears in the operator value three cycles after the slot begins. A wrong operator subset in the mixer appears in `chanOut` one cycle after the fourth operator of that channel. A slip in the slot counter moves `opIdx` away from `slotIdx` and changes the strobe counts per frame. Skipped operators that still advanced internally show up as wrong values in the first frame after the skip ends.

// File: rtl/fmop_pkg.sv
`timescale 1ns/1ps
package fmop_pkg;

  typedef struct packed {
    logic acc;      // advance accumulator, capture phase and attenuation
    logic lookup;   // log-sine lookup plus attenuation
    logic convert;  // exponent lookup, shift and sign
    logic mix;      // channel combine
  } fmopStrobeT;

  localparam int FRAC_W      = 8;   // fractional bits of the log domain
  localparam int EXP_BASE_W  = 11;  // width of exponent table entries
  localparam int SHIFT_BIAS  = 2;   // integer part offset before shifting

  function automatic int logSinEntry(int i, int n);
    real ang;
    real s;
    ang = (2.0 * i + 1.0) * 3.14159265358979323846 / (4.0 * n);
    s = $sin(ang);
    return $rtoi($floor(-($ln(s) / $ln(2.0)) * 256.0 + 0.5));
  endfunction

  function automatic int expEntry(int f);
    return $rtoi($floor($pow(2.0, -(f + 1.0) / 256.0) * 2048.0 + 0.5));
  endfunction

endpackage

// File: rtl/fmop_logsin_rom.sv
`timescale 1ns/1ps
module fmop_logsin_rom #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int N = 2 ** ADDR_W;

  logic [DATA_W-1:0] tab [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    localparam int VAL = fmop_pkg::logSinEntry(i, N);
    assign tab[i] = DATA_W'(VAL);
  end

  assign data = tab[addr];
endmodule

// File: rtl/fmop_exp_rom.sv
`timescale 1ns/1ps
module fmop_exp_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int N = 2 ** ADDR_W;

  logic [DATA_W-1:0] tab [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    localparam int VAL = fmop_pkg::expEntry(i);
    assign tab[i] = DATA_W'(VAL);
  end

  assign data = tab[addr];
endmodule

// File: rtl/fmop_ctrl.sv
`timescale 1ns/1ps
module fmop_ctrl
  import fmop_pkg::*;
#(
  parameter int NUM_OPS    = 24,
  parameter int OPS_PER_CH = 4,
  parameter int SLOT_CYC   = 6,
  localparam int SLOT_W    = $clog2(NUM_OPS),
  localparam int SUB_W     = $clog2(SLOT_CYC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dacEnable,
  output logic [SLOT_W-1:0] slot,
  output fmopStrobeT        strobe
);
  logic [SUB_W-1:0]  subCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              activeQ;
  logic              lastCh;
  logic              lastInCh;
  logic              skipNow;

  assign lastCh   = slotCnt >= SLOT_W'(NUM_OPS - OPS_PER_CH);
  assign lastInCh = (int'(slotCnt) % OPS_PER_CH) == (OPS_PER_CH - 1);
  assign skipNow  = dacEnable && lastCh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt  <= '0;
      slotCnt <= '0;
      activeQ <= 1'b0;
    end else begin
      if (subCnt == SUB_W'(SLOT_CYC - 1)) begin
        subCnt  <= '0;
        slotCnt <= (slotCnt == SLOT_W'(NUM_OPS - 1)) ? '0 : slotCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
      if (subCnt == '0) activeQ <= !skipNow;
    end
  end

  always_comb begin
    strobe.acc     = (subCnt == '0) && !skipNow;
    strobe.lookup  = (subCnt == SUB_W'(1)) && activeQ;
    strobe.convert = (subCnt == SUB_W'(2)) && activeQ;
    strobe.mix     = (subCnt == SUB_W'(3)) && activeQ && lastInCh;
  end

  assign slot = slotCnt;
endmodule

// File: rtl/fmop_datapath.sv
`timescale 1ns/1ps
module fmop_datapath
  import fmop_pkg::*;
#(
  parameter int NUM_OPS    = 24,
  parameter int OPS_PER_CH = 4,
  parameter int ACC_W      = 32,
  parameter int PH_LSB     = 10,
  parameter int PH_W       = 10,
  parameter int ENV_W      = 13,
  parameter int OUT_W      = 16,
  localparam int SLOT_W    = $clog2(NUM_OPS),
  localparam int CH_W      = $clog2(NUM_OPS / OPS_PER_CH),
  localparam int MAG_W     = EXP_BASE_W + SHIFT_BIAS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fmopStrobeT              strobe,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [ACC_W-1:0]        phaseInc,
  input  logic [ENV_W-1:0]        envAtten,
  input  logic [2:0]              chanAlg,
  output logic                    opValid,
  output logic [SLOT_W-1:0]       opIdx,
  output logic signed [OUT_W-1:0] opOut,
  output logic                    chanValid,
  output logic [CH_W-1:0]         chanIdx,
  output logic signed [OUT_W-1:0] chanOut
);
  logic [ACC_W-1:0]        accum   [NUM_OPS];
  logic signed [OUT_W-1:0] opStore [NUM_OPS];

  logic [PH_W-1:0]         phaseQ;
  logic [ENV_W-1:0]        envQ;
  logic [ENV_W-1:0]        idxQ;
  logic                    signQ;

  logic [ACC_W-1:0]        accSum;
  logic [ENV_W-1:0]        logSin;
  logic [ENV_W:0]          rawIdx;
  logic [ENV_W-1:0]        satIdx;
  logic [EXP_BASE_W-1:0]   expBase;
  logic [MAG_W-1:0]        magBase;
  logic [MAG_W-1:0]        mag;
  int                      shAmt;
  logic signed [OUT_W-1:0] opRes;
  logic [SLOT_W-1:0]       chBase;
  logic signed [OUT_W-1:0] chOp [OPS_PER_CH];
  logic signed [OUT_W-1:0] mixSum;

  fmop_logsin_rom #(.ADDR_W(PH_W - 1), .DATA_W(ENV_W)) u_logsin (
    .addr(phaseQ[PH_W-2:0]),
    .data(logSin)
  );

  fmop_exp_rom #(.ADDR_W(FRAC_W), .DATA_W(EXP_BASE_W)) u_exp (
    .addr(idxQ[FRAC_W-1:0]),
    .data(expBase)
  );

  assign accSum = accum[slot] + phaseInc;
  assign rawIdx = {1'b0, logSin} + {1'b0, envQ};
  assign satIdx = rawIdx[ENV_W] ? '1 : rawIdx[ENV_W-1:0];

  always_comb begin
    shAmt   = int'(idxQ[ENV_W-1:FRAC_W]) - SHIFT_BIAS;
    magBase = MAG_W'(expBase);
    if (shAmt < 0) mag = magBase << (-shAmt);
    else           mag = magBase >> shAmt;
    opRes = signQ ? -$signed(OUT_W'(mag)) : $signed(OUT_W'(mag));
  end

  assign chBase = slot - SLOT_W'(OPS_PER_CH - 1);

  for (genvar k = 0; k < OPS_PER_CH; k++) begin : g_chop
    assign chOp[k] = opStore[chBase + SLOT_W'(k)];
  end

  always_comb begin
    case (chanAlg)
      3'd4:       mixSum = chOp[3] + chOp[1];
      3'd5, 3'd6: mixSum = chOp[1] + chOp[2] + chOp[3];
      3'd7:       mixSum = chOp[0] + chOp[1] + chOp[2] + chOp[3];
      default:    mixSum = chOp[3];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_OPS; k++) begin
        accum[k]   <= '0;
        opStore[k] <= '0;
      end
      phaseQ    <= '0;
      envQ      <= '0;
      idxQ      <= '0;
      signQ     <= 1'b0;
      opValid   <= 1'b0;
      opIdx     <= '0;
      opOut     <= '0;
      chanValid <= 1'b0;
      chanIdx   <= '0;
      chanOut   <= '0;
    end else begin
      opValid   <= 1'b0;
      chanValid <= 1'b0;
      if (strobe.acc) begin
        accum[slot] <= accSum;
        phaseQ      <= accSum[PH_LSB +: PH_W];
        envQ        <= envAtten;
      end
      if (strobe.lookup) begin
        idxQ  <= satIdx;
        signQ <= phaseQ[PH_W-1];
      end
      if (strobe.convert) begin
        opStore[slot] <= opRes;
        opOut         <= opRes;
        opIdx         <= slot;
        opValid       <= 1'b1;
      end
      if (strobe.mix) begin
        chanOut   <= mixSum;
        chanIdx   <= CH_W'(int'(slot) / OPS_PER_CH);
        chanValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fmop_core.sv
`timescale 1ns/1ps
module fmop_core #(
  parameter int NUM_OPS    = 24,
  parameter int OPS_PER_CH = 4,
  parameter int SLOT_CYC   = 6,
  parameter int ACC_W      = 32,
  parameter int PH_LSB     = 10,
  parameter int PH_W       = 10,
  parameter int ENV_W      = 13,
  parameter int OUT_W      = 16,
  localparam int SLOT_W    = $clog2(NUM_OPS),
  localparam int CH_W      = $clog2(NUM_OPS / OPS_PER_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    dacEnable,
  input  logic [ACC_W-1:0]        phaseInc,
  input  logic [ENV_W-1:0]        envAtten,
  input  logic [2:0]              chanAlg,
  output logic [SLOT_W-1:0]       slotIdx,
  output logic                    opValid,
  output logic [SLOT_W-1:0]       opIdx,
  output logic signed [OUT_W-1:0] opOut,
  output logic                    chanValid,
  output logic [CH_W-1:0]         chanIdx,
  output logic signed [OUT_W-1:0] chanOut
);
  fmop_pkg::fmopStrobeT strobe;

  fmop_ctrl #(
    .NUM_OPS(NUM_OPS), .OPS_PER_CH(OPS_PER_CH), .SLOT_CYC(SLOT_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .dacEnable(dacEnable),
    .slot(slotIdx), .strobe(strobe)
  );

  fmop_datapath #(
    .NUM_OPS(NUM_OPS), .OPS_PER_CH(OPS_PER_CH), .ACC_W(ACC_W),
    .PH_LSB(PH_LSB), .PH_W(PH_W), .ENV_W(ENV_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slotIdx),
    .phaseInc(phaseInc), .envAtten(envAtten), .chanAlg(chanAlg),
    .opValid(opValid), .opIdx(opIdx), .opOut(opOut),
    .chanValid(chanValid), .chanIdx(chanIdx), .chanOut(chanOut)
  );
endmodule

// File: rtl/fmop_core_checker.sv
`timescale 1ns/1ps
module fmop_core_checker #(
  parameter int NUM_OPS    = 24,
  parameter int OPS_PER_CH = 4,
  parameter int OUT_W      = 16,
  localparam int SLOT_W    = $clog2(NUM_OPS),
  localparam int CH_W      = $clog2(NUM_OPS / OPS_PER_CH),
  localparam int MAX_MAG   = 8168
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    dacEnable,
  input logic [SLOT_W-1:0]       slotIdx,
  input logic                    opValid,
  input logic [SLOT_W-1:0]       opIdx,
  input logic signed [OUT_W-1:0] opOut,
  input logic                    chanValid,
  input logic [CH_W-1:0]         chanIdx
);
  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx != $past(slotIdx)) |->
      (slotIdx == (($past(slotIdx) == SLOT_W'(NUM_OPS - 1)) ? '0 : $past(slotIdx) + 1'b1)));

  p_op_in_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> (opIdx == slotIdx));

  p_op_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid);

  p_op_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> (int'(opOut) <= MAX_MAG && int'(opOut) >= -MAX_MAG));

  p_chan_last_op_r8: assert property (@(posedge clk) disable iff (!rstN)
    chanValid |-> ((int'(slotIdx) % OPS_PER_CH) == OPS_PER_CH - 1 &&
                   int'(chanIdx) == int'(slotIdx) / OPS_PER_CH));

  p_chan_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    chanValid |=> !chanValid);

  p_dac_skip_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && int'(opIdx) >= NUM_OPS - OPS_PER_CH) |-> !$past(dacEnable, 3));
endmodule

bind fmop_core fmop_core_checker #(
  .NUM_OPS(NUM_OPS), .OPS_PER_CH(OPS_PER_CH), .OUT_W(OUT_W)
) u_check (
  .clk(clk), .rstN(rstN), .dacEnable(dacEnable), .slotIdx(slotIdx),
  .opValid(opValid), .opIdx(opIdx), .opOut(opOut),
  .chanValid(chanValid), .chanIdx(chanIdx)
);

// File: tb/fmop_core_bench.sv
`timescale 1ns/1ps
module fmop_core_bench;
  localparam int NOPS = 24;
  localparam int NCH  = 6;
  localparam int FRAME = 144;

  typedef struct packed {
    logic [31:0] inc;
    logic [12:0] env;
    logic [2:0]  alg;
    logic        dac;
  } vecT;

  // Stimulus seeds; expected results come from the bench model below.
  localparam vecT VECS [5] = '{
    '{32'h0001_2345, 13'd0,   3'd0, 1'b0},
    '{32'h00A5_5A11, 13'd300, 3'd2, 1'b0},
    '{32'hFFFF_FC00, 13'd40,  3'd4, 1'b0},
    '{32'h0003_1F07, 13'd90,  3'd5, 1'b1},
    '{32'h0123_4567, 13'd7,   3'd1, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rstN;
  logic               dacReg;
  logic [31:0]        incArr [NOPS];
  logic [12:0]        envArr [NOPS];
  logic [2:0]         algArr [NCH];
  logic [31:0]        phaseInc;
  logic [12:0]        envAtten;
  logic [2:0]         chanAlg;
  logic [4:0]         slotIdx;
  logic               opValid;
  logic [4:0]         opIdx;
  logic signed [15:0] opOut;
  logic               chanValid;
  logic [2:0]         chanIdx;
  logic signed [15:0] chanOut;

  assign phaseInc = incArr[slotIdx];
  assign envAtten = envArr[slotIdx];
  assign chanAlg  = algArr[slotIdx / 4];

  fmop_core u_fmop_core (
    .clk(clk), .rstN(rstN), .dacEnable(dacReg),
    .phaseInc(phaseInc), .envAtten(envAtten), .chanAlg(chanAlg),
    .slotIdx(slotIdx), .opValid(opValid), .opIdx(opIdx), .opOut(opOut),
    .chanValid(chanValid), .chanIdx(chanIdx), .chanOut(chanOut)
  );

  int          nChecks = 0;
  int          nFails  = 0;
  logic [31:0] mAcc [NOPS];
  int          mOp  [NOPS];
  int          capOp [NOPS];
  int          capChan [NCH];
  int          opSeen, chanSeen;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int modelOp(int ph, int env);
    real x;
    int ls, idx, f, v, s, mag;
    x   = $sin((2.0 * (ph % 512) + 1.0) * 3.14159265358979323846 / 2048.0);
    ls  = $rtoi($floor(-($ln(x) / $ln(2.0)) * 256.0 + 0.5));
    idx = ls + env;
    if (idx > 8191) idx = 8191;
    f   = idx % 256;
    v   = $rtoi($floor($pow(2.0, -(f + 1.0) / 256.0) * 2048.0 + 0.5));
    s   = idx / 256 - 2;
    mag = (s < 0) ? (v << (-s)) : (v >> s);
    return (ph >= 512) ? -mag : mag;
  endfunction

  function automatic int mixModel(int alg, int o0, int o1, int o2, int o3);
    case (alg)
      4:       return o3 + o1;
      5, 6:    return o1 + o2 + o3;
      7:       return o0 + o1 + o2 + o3;
      default: return o3;
    endcase
  endfunction

  task automatic checkCycle();
    if (opValid) begin
      int k, ph, e;
      k = int'(opIdx);
      mAcc[k] = mAcc[k] + incArr[k];
      ph = int'(mAcc[k][19:10]);
      e = modelOp(ph, int'(envArr[k]));
      mOp[k] = e;
      capOp[k] = int'(opOut);
      opSeen++;
      check("R2 R3 R4 R5 R6 operator value", int'(opOut), e);
      check("R7 opIdx matches slotIdx", int'(opIdx), int'(slotIdx));
    end
    if (chanValid) begin
      int c, e;
      c = int'(chanIdx);
      e = mixModel(int'(algArr[c]), mOp[c*4], mOp[c*4+1], mOp[c*4+2], mOp[c*4+3]);
      capChan[c] = int'(chanOut);
      chanSeen++;
      check("R8 channel mix", int'(chanOut), e);
    end
  endtask

  task automatic runFrame(bit dac);
    opSeen = 0;
    chanSeen = 0;
    repeat (FRAME) begin
      @(negedge clk);
      checkCycle();
    end
    check("R7 R9 operator strobes per frame", opSeen, dac ? 20 : 24);
    check("R8 R9 channel strobes per frame", chanSeen, dac ? 5 : 6);
    check("R1 frame realigns to slot 0", int'(slotIdx), 0);
  endtask

  initial begin
    rstN = 1'b0;
    dacReg = 1'b0;
    for (int k = 0; k < NOPS; k++) begin
      incArr[k] = 32'h0;
      envArr[k] = 13'h0;
      mAcc[k] = 32'h0;
      mOp[k] = 0;
    end
    for (int c = 0; c < NCH; c++) algArr[c] = 3'd0;
    repeat (3) @(negedge clk);

    // R10: reset state
    check("R10 slotIdx in reset", int'(slotIdx), 0);
    check("R10 opValid in reset", int'(opValid), 0);
    check("R10 chanValid in reset", int'(chanValid), 0);
    check("R10 opOut in reset", int'(opOut), 0);
    check("R10 chanOut in reset", int'(chanOut), 0);

    // Directed frame with hand-computed values
    incArr[0]  = 32'h0007_FC00;                       // phase 511: peak
    incArr[1]  = 32'h000F_FC00;                       // phase 1023: negative peak
    incArr[2]  = 32'h0;  envArr[2]  = 13'd8191;       // saturation -> 0
    incArr[3]  = 32'h0007_FC00; envArr[3] = 13'd256;  // left shift by 1
    incArr[4]  = 32'h0007_FC00; envArr[4] = 13'd512;  // no shift
    incArr[5]  = 32'h0007_FC00; envArr[5] = 13'd768;  // right shift by 1
    incArr[6]  = 32'h000F_FC00;
    incArr[7]  = 32'h0007_FC00;
    incArr[8]  = 32'h0007_FC00;
    incArr[9]  = 32'h0007_FC00; envArr[9]  = 13'd768;
    incArr[10] = 32'h0007_FC00; envArr[10] = 13'd512;
    incArr[11] = 32'h000F_FC00;
    algArr[0] = 3'd7; algArr[1] = 3'd4; algArr[2] = 3'd5;
    rstN = 1'b1;
    runFrame(1'b0);
    check("R5 peak magnitude", capOp[0], 8168);
    check("R6 negated peak", capOp[1], -8168);
    check("R4 saturated index gives zero", capOp[2], 0);
    check("R5 left shift by one", capOp[3], 4084);
    check("R5 unshifted base", capOp[4], 2042);
    check("R5 right shift by one", capOp[5], 1021);
    check("R8 algorithm 7 sum", capChan[0], 4084);
    check("R8 algorithm 4 sum", capChan[1], 9189);
    check("R8 algorithm 5 sum", capChan[2], -5105);

    // R1: slot length
    begin
      int n;
      n = 0;
      do begin
        @(negedge clk);
        checkCycle();
        n++;
      end while (slotIdx == 5'd0);
      check("R1 slot length in cycles", n, 6);
      check("R1 slot steps to 1", int'(slotIdx), 1);
      repeat (FRAME - n) begin
        @(negedge clk);
        checkCycle();
      end
      check("R1 frame length 144", int'(slotIdx), 0);
    end

    // Vector table walk
    for (int v = 0; v < 5; v++) begin
      for (int k = 0; k < NOPS; k++) begin
        incArr[k] = VECS[v].inc * 32'(k + 1);
        envArr[k] = VECS[v].env + 13'(k * 150);
      end
      for (int c = 0; c < NCH; c++) algArr[c] = VECS[v].alg + 3'(c);
      dacReg = VECS[v].dac;
      runFrame(VECS[v].dac);
      runFrame(VECS[v].dac);
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFails + 1);
    $finish;
  end
endmodule